// File: doc/BRIEF.md
# Error Record Register Access Controller

This block sits between the system-register access path of a processor and a small bank of error status records. Each request carries a register encoding, a direction and the current exception level. The block checks the encoding, then runs a fixed-priority chain over a set of trap and privilege controls. The chain settles on one of four outcomes: undefined, trap to EL2, trap to EL3, or permitted. Only a permitted access touches the record bank.

A select register names the target record. An access whose select value is not below the number of implemented records reaches no record. Such a read returns zero and such a write is dropped, but the verdict is still computed as normal. The verdict, an exception class and any read data all appear one clock after the request. Exception entry and the meaning of the status fields are left to the surrounding logic.

Top module: `errrec_access_ctrl`

## Requirements
- R1: A strobe follows a request only when `req_valid` is high and the encoding is op0=2'b11, op1=3'b000, CRn=4'b0101, CRm=4'b0100, op2=3'b010. Any other encoding gives no strobe and changes no record.
- R2: `vld_o` rises in the cycle after a matching request. While it is high, `verdict_o` is one-hot with bit 0 = undefined, bit 1 = trap to EL2, bit 2 = trap to EL3 and bit 3 = permitted. While it is low, `verdict_o` is zero.
- R3: With `req_el` = 0 (EL0), every access is undefined. The codes 1, 2 and 3 stand for EL1, EL2 and EL3.
- R4: At EL1 the first matching check wins, in this order:
  1. Undefined when EL3 is present, undefined-priority is set and the EL3 trap-error bit is set.
  2. Undefined for a write when the same holds with the EL3 trap-write-error bit.
  3. Trap to EL2 when EL2 is enabled and the EL2 trap-error bit is set.
  4. Trap to EL2 when EL2 is enabled, fine-grained traps are implemented, EL3 is absent or its fine-grained enable is set, and the fine-grained bit for this direction (read or write) is set.
  5. Trap to EL3 when EL3 is present and the trap-error bit is set, or, for a write, the trap-write-error bit is set.
  6. Otherwise permitted.
- R5: When the check that would trap to EL3 (at EL1 or EL2) matches and `sdd_undef` is set, the verdict is undefined instead.
- R6: At EL2 only the EL3 checks apply: the undefined-priority checks first, then the EL3 trap check. The EL2 and fine-grained controls have no effect, and trap-write-error acts on writes only.
- R7: At EL3 every matching access is permitted.
- R8: `ec_o` is 6'h18 with either trap verdict. It is zero otherwise.
- R9: A permitted in-range write stores `req_wdata` into the selected record. A write with any other verdict leaves all records unchanged.
- R10: A permitted in-range read returns the selected record on `rdata_o`. In every other cycle `rdata_o` is zero.
- R11: A select value at or above `NUM_REC` reaches no record: reads return zero and writes are dropped. The verdict is unaffected.
- R12: `sel_we` loads `sel_din` into the select register. An access in the same cycle uses the value held before that cycle.
- R13: After reset, `vld_o`, `verdict_o`, `ec_o` and `rdata_o` are zero and the select register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Current exception level, 0..3 |
| req_wdata | input | DATA_W | Write data |
| sel_we | input | 1 | Load the record select register |
| sel_din | input | SEL_W | New select value |
| el3_present | input | 1 | EL3 implemented |
| el3_terr | input | 1 | EL3 trap on error-record access |
| el3_twerr | input | 1 | EL3 trap on error-record writes |
| el3_fgt_en | input | 1 | EL3 allows EL2 fine-grained traps |
| undef_prio | input | 1 | EL3 trap controls give undefined at top priority |
| sdd_undef | input | 1 | Turn EL3 traps into undefined |
| el2_enabled | input | 1 | EL2 enabled |
| el2_terr | input | 1 | EL2 trap on error-record access |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| fgt_rd | input | 1 | Fine-grained read trap for this register |
| fgt_wr | input | 1 | Fine-grained write trap for this register |
| vld_o | output | 1 | Verdict valid |
| verdict_o | output | 4 | One-hot verdict |
| ec_o | output | 6 | Exception class |
| rdata_o | output | DATA_W | Read data |

## Verification
A select-register load and a record access can fall in the same cycle. The access must use the old select value, while the new value governs the next access. The bench provokes this on nearly every request: while it sweeps all exception levels, directions and all 2048 control combinations, it reloads the select register, including values beyond the implemented count. A behavioural model keeps the select value and the record contents. It applies the access with the old select value before the load, and the strobe, verdict, exception class and read data are compared with the model every clock.

// File: rtl/errrec_pkg.sv
package errrec_pkg;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0101;
  localparam logic [3:0] ENC_CRM = 4'b0100;
  localparam logic [2:0] ENC_OP2 = 3'b010;

  localparam logic [1:0] LVL_0 = 2'd0;
  localparam logic [1:0] LVL_1 = 2'd1;
  localparam logic [1:0] LVL_2 = 2'd2;

  localparam logic [3:0] V_UNDEF  = 4'b0001;
  localparam logic [3:0] V_TRAP2  = 4'b0010;
  localparam logic [3:0] V_TRAP3  = 4'b0100;
  localparam logic [3:0] V_PERMIT = 4'b1000;

  localparam logic [5:0] EC_TRAP = 6'h18;

  typedef struct packed {
    logic el3_present;
    logic el3_terr;
    logic el3_twerr;
    logic el3_fgt_en;
    logic undef_prio;
    logic sdd_undef;
    logic el2_enabled;
    logic el2_terr;
    logic fgt_impl;
    logic fgt_rd;
    logic fgt_wr;
  } ctrl_t;

endpackage

// File: rtl/errrec_decode.sv
module errrec_decode
  import errrec_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  logic enc_ok;
  assign enc_ok = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN)
               && (crm == ENC_CRM) && (op2 == ENC_OP2);
  assign hit = valid && enc_ok;
endmodule

// File: rtl/errrec_priority.sv
module errrec_priority
  import errrec_pkg::*;
(
  input  logic [1:0] el,
  input  logic       is_wr,
  input  ctrl_t      c,
  output logic [3:0] verdict,
  output logic [5:0] ec
);
  logic top_undef;
  logic el2_hyp;
  logic el2_fine;
  logic el3_trap;
  logic [3:0] el3_out;

  // Top-priority undefined from EL3 controls (write-only leg included)
  assign top_undef = c.el3_present && c.undef_prio
                  && (c.el3_terr || (is_wr && c.el3_twerr));
  assign el2_hyp   = c.el2_enabled && c.el2_terr;
  assign el2_fine  = c.el2_enabled && c.fgt_impl
                  && (!c.el3_present || c.el3_fgt_en)
                  && (is_wr ? c.fgt_wr : c.fgt_rd);
  assign el3_trap  = c.el3_present && (c.el3_terr || (is_wr && c.el3_twerr));
  assign el3_out   = c.sdd_undef ? V_UNDEF : V_TRAP3;

  always_comb begin
    verdict = V_PERMIT;
    unique case (el)
      LVL_0: verdict = V_UNDEF;
      LVL_1: begin
        if (top_undef)              verdict = V_UNDEF;
        else if (el2_hyp)           verdict = V_TRAP2;
        else if (el2_fine)          verdict = V_TRAP2;
        else if (el3_trap)          verdict = el3_out;
        else                        verdict = V_PERMIT;
      end
      LVL_2: begin
        if (top_undef)              verdict = V_UNDEF;
        else if (el3_trap)          verdict = el3_out;
        else                        verdict = V_PERMIT;
      end
      default:                      verdict = V_PERMIT;
    endcase
  end

  assign ec = (verdict[1] || verdict[2]) ? EC_TRAP : 6'd0;
endmodule

// File: rtl/errrec_bank.sv
module errrec_bank #(
  parameter int NUM_REC = 8,
  parameter int DATA_W  = 64,
  parameter int SEL_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_range,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = (NUM_REC > 0) ? NUM_REC : 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              rd_en_q;
  logic [DATA_W-1:0] rd_q;

  generate
    if (NUM_REC == 0) begin : g_empty
      assign in_range = 1'b0;
      always_ff @(posedge clk) rd_q <= '0;
      logic unused_ok;
      assign unused_ok = &{1'b0, sel, wr_go, wdata};
    end else begin : g_mem
      logic [DATA_W-1:0] mem [DEPTH];
      logic [IDX_W-1:0]  idx;
      assign in_range = ({1'b0, sel} < (SEL_W+1)'(NUM_REC));
      assign idx      = IDX_W'(sel);
      always_ff @(posedge clk) begin
        if (wr_go && in_range) mem[idx] <= wdata;
        rd_q <= mem[idx];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_en_q <= 1'b0;
    else     rd_en_q <= rd_go && in_range;
  end

  assign rdata = rd_en_q ? rd_q : '0;
endmodule

// File: rtl/errrec_access_ctrl.sv
module errrec_access_ctrl
  import errrec_pkg::*;
#(
  parameter int NUM_REC = 8,
  parameter int DATA_W  = 64,
  parameter int SEL_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [1:0]        req_el,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_din,
  input  logic              el3_present,
  input  logic              el3_terr,
  input  logic              el3_twerr,
  input  logic              el3_fgt_en,
  input  logic              undef_prio,
  input  logic              sdd_undef,
  input  logic              el2_enabled,
  input  logic              el2_terr,
  input  logic              fgt_impl,
  input  logic              fgt_rd,
  input  logic              fgt_wr,
  output logic              vld_o,
  output logic [3:0]        verdict_o,
  output logic [5:0]        ec_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctl;
  logic              hit;
  logic [3:0]        verdict_c;
  logic [5:0]        ec_c;
  logic              permit;
  logic [SEL_W-1:0]  sel_q;
  logic              in_range;

  assign ctl = '{el3_present: el3_present, el3_terr: el3_terr,
                 el3_twerr: el3_twerr, el3_fgt_en: el3_fgt_en,
                 undef_prio: undef_prio, sdd_undef: sdd_undef,
                 el2_enabled: el2_enabled, el2_terr: el2_terr,
                 fgt_impl: fgt_impl, fgt_rd: fgt_rd, fgt_wr: fgt_wr};

  errrec_decode u_dec (
    .valid(req_valid), .op0(req_op0), .op1(req_op1),
    .crn(req_crn), .crm(req_crm), .op2(req_op2), .hit(hit)
  );

  errrec_priority u_prio (
    .el(req_el), .is_wr(req_write), .c(ctl),
    .verdict(verdict_c), .ec(ec_c)
  );

  assign permit = hit && verdict_c[3];

  errrec_bank #(.NUM_REC(NUM_REC), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .sel(sel_q),
    .wr_go(permit && req_write), .rd_go(permit && !req_write),
    .wdata(req_wdata), .in_range(in_range), .rdata(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      verdict_o <= '0;
      ec_o      <= '0;
      sel_q     <= '0;
    end else begin
      vld_o     <= hit;
      verdict_o <= hit ? verdict_c : 4'd0;
      ec_o      <= hit ? ec_c : 6'd0;
      if (sel_we) sel_q <= sel_din;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, in_range};
endmodule

// File: rtl/errrec_access_chk.sv
module errrec_access_chk
  import errrec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op0,
  input logic [2:0]        req_op1,
  input logic [3:0]        req_crn,
  input logic [3:0]        req_crm,
  input logic [2:0]        req_op2,
  input logic [1:0]        req_el,
  input logic              vld_o,
  input logic [3:0]        verdict_o,
  input logic [5:0]        ec_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic match;
  assign match = req_valid && req_op0 == 2'b11 && req_op1 == 3'b000
              && req_crn == 4'b0101 && req_crm == 4'b0100 && req_op2 == 3'b010;

  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    match |=> vld_o);
  assert_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !match |=> !vld_o);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $countones(verdict_o) == 1);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> verdict_o == 4'd0);
  assert_el0_undef_R3: assert property (@(posedge clk) disable iff (rst)
    (match && req_el == 2'd0) |=> verdict_o == 4'b0001);
  assert_el3_permit_R7: assert property (@(posedge clk) disable iff (rst)
    (match && req_el == 2'd3) |=> verdict_o == 4'b1000);
  assert_trap_ec_R8: assert property (@(posedge clk) disable iff (rst)
    (vld_o && (verdict_o[1] || verdict_o[2])) |-> ec_o == 6'h18);
  assert_plain_ec_R8: assert property (@(posedge clk) disable iff (rst)
    !(vld_o && (verdict_o[1] || verdict_o[2])) |-> ec_o == 6'd0);
  assert_rdata_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !(vld_o && verdict_o[3]) |-> rdata_o == '0);
endmodule

bind errrec_access_ctrl errrec_access_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
  .req_crm(req_crm), .req_op2(req_op2), .req_el(req_el),
  .vld_o(vld_o), .verdict_o(verdict_o), .ec_o(ec_o), .rdata_o(rdata_o)
);

// File: tb/errrec_access_ctrl_tb.sv
`timescale 1ns/1ps
module errrec_access_ctrl_tb;
  localparam int NREC = 8;
  localparam int DW   = 64;
  localparam int SW   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_op0 = 0; logic [2:0] req_op1 = 0;
  logic [3:0] req_crn = 0, req_crm = 0; logic [2:0] req_op2 = 0;
  logic [1:0] req_el = 0;
  logic [DW-1:0] req_wdata = 0;
  logic sel_we = 0; logic [SW-1:0] sel_din = 0;
  logic el3_present = 0, el3_terr = 0, el3_twerr = 0, el3_fgt_en = 0;
  logic undef_prio = 0, sdd_undef = 0, el2_enabled = 0, el2_terr = 0;
  logic fgt_impl = 0, fgt_rd = 0, fgt_wr = 0;
  logic vld_o; logic [3:0] verdict_o; logic [5:0] ec_o; logic [DW-1:0] rdata_o;

  always #4 clk = ~clk;

  errrec_access_ctrl #(.NUM_REC(NREC), .DATA_W(DW), .SEL_W(SW)) u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] mmem [NREC];
  int msel = 0;

  // ctrl bit order: 0 el3_present,1 el2_enabled,2 fgt_impl,3 el3_fgt_en,
  // 4 el3_terr,5 el3_twerr,6 el2_terr,7 fgt_rd,8 fgt_wr,9 undef_prio,10 sdd_undef
  function automatic logic [3:0] ref_verdict(int el, bit w, logic [10:0] c);
    bit e3 = c[0], e2 = c[1];
    bit t3 = c[4], tw = c[5] && w;
    if (el == 0) return 4'b0001;
    if (el == 3) return 4'b1000;
    if (e3 && c[9] && t3) return 4'b0001;
    if (e3 && c[9] && tw) return 4'b0001;
    if (el == 1) begin
      if (e2 && c[6]) return 4'b0010;
      if (e2 && c[2] && (!e3 || c[3]) && (w ? c[8] : c[7])) return 4'b0010;
    end
    if (e3 && (t3 || tw)) return c[10] ? 4'b0001 : 4'b0100;
    return 4'b1000;
  endfunction

  task automatic step(input bit v, input bit w, input int el, input logic [10:0] c,
                      input logic [DW-1:0] wd, input bit swe, input int sd,
                      input bit good, input string tag);
    logic [3:0] ev; logic [5:0] eec; logic [DW-1:0] erd; bit evld;
    bit inr;
    req_valid = v; req_write = w; req_el = el[1:0]; req_wdata = wd;
    req_op0 = 2'b11; req_op1 = 3'b000; req_crn = 4'b0101; req_crm = 4'b0100;
    req_op2 = good ? 3'b010 : 3'b011;
    {sdd_undef, undef_prio, fgt_wr, fgt_rd, el2_terr, el3_twerr, el3_terr,
     el3_fgt_en, fgt_impl, el2_enabled, el3_present} = c;
    sel_we = swe; sel_din = SW'(sd);
    evld = v && good;
    ev = evld ? ref_verdict(el, w, c) : 4'd0;
    eec = (ev == 4'b0010 || ev == 4'b0100) ? 6'h18 : 6'd0;
    inr = (msel < NREC);
    erd = '0;
    if (ev == 4'b1000 && inr) begin
      if (w) mmem[msel] = wd;
      else   erd = mmem[msel];
    end
    if (swe) msel = sd;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (vld_o !== evld || verdict_o !== ev || ec_o !== eec || rdata_o !== erd) begin
      bad++;
      $display("FAIL %s R2 vld=%0b/%0b verdict=%b/%b R8 ec=%h/%h R10 rdata=%h/%h",
               tag, vld_o, evld, verdict_o, ev, ec_o, eec, rdata_o, erd);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (vld_o !== 1'b0 || verdict_o !== 4'd0 || ec_o !== 6'd0 || rdata_o !== '0) begin
      bad++;
      $display("FAIL R13 reset outputs vld=%0b verdict=%b ec=%h rdata=%h expected all zero",
               vld_o, verdict_o, ec_o, rdata_o);
    end
    rst = 0;
    // R13: first write lands in record 0 (select resets to 0); R9 fill all records
    for (int r = 0; r < NREC; r++)
      step(1, 1, 3, 11'd0, 64'hA5A5_0000_0000_0000 | 64'(r * 17 + 3), 1, (r + 1) % NREC, 1, "R9");
    for (int r = 0; r < NREC; r++)
      step(1, 0, 3, 11'd0, '0, 1, (r + 1) % NREC, 1, "R10");
    // R12: select load and access together
    step(1, 0, 3, 11'd0, '0, 1, 5, 1, "R12");
    step(1, 0, 3, 11'd0, '0, 0, 0, 1, "R12");
    // R1: non-matching encoding changes nothing
    step(1, 1, 3, 11'd0, 64'hDEAD, 0, 0, 0, "R1");
    step(0, 1, 3, 11'd0, 64'hBEEF, 0, 0, 1, "R1");
    step(1, 0, 3, 11'd0, '0, 0, 0, 1, "R1");
    // R9: trapped write leaves record intact
    step(1, 1, 1, 11'b000_0101_0001, 64'h1111, 0, 0, 1, "R9");
    step(1, 0, 3, 11'd0, '0, 0, 0, 1, "R9");
    // R11: out of range
    step(0, 0, 3, 11'd0, '0, 1, NREC, 1, "R11");
    step(1, 1, 3, 11'd0, 64'h7777, 0, 0, 1, "R11");
    step(1, 0, 3, 11'd0, '0, 1, 16'hFFFF, 1, "R11");
    step(1, 1, 1, 11'b000_0001_0001, 64'h8888, 0, 0, 1, "R11");
    step(1, 0, 3, 11'd0, '0, 1, 0, 1, "R11");
    for (int r = 0; r < NREC; r++)
      step(1, 0, 3, 11'd0, '0, 1, (r + 1) % NREC, 1, "R11");
    // R3 R4 R5 R6 R7 sweep, select reloaded each request (R12)
    for (int c = 0; c < 2048; c++)
      for (int el = 0; el < 4; el++)
        for (int w = 0; w < 2; w++)
          step(1, w[0], el, c[10:0], {32'(c), 16'(el), 16'(w) ^ 16'h5A5A},
               1, (c + el * 3 + w) % 10, 1,
               el == 0 ? "R3" : el == 1 ? "R4/R5" : el == 2 ? "R6/R5" : "R7");
    step(0, 0, 0, 11'd0, '0, 0, 0, 1, "R2");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule